// File: doc/BRIEF.md
# Gigabit Fiber Link Bring-Up and Transmit Gate

This block decides when a gigabit fiber MAC port may start sending. It keeps a small configuration register. One bit of that register chooses between two modes. In forced mode the port runs at a fixed 1000 Mbps full duplex and never negotiates. In negotiation mode the port waits for a negotiation engine, which sits outside this block, to report completion. In both modes the transmit path stays closed until the receive side reports that it is synchronized with the link partner.

While transmit is closed, the two-bit status sent toward the host-side transmit FIFO shows the satisfied code. This stops the host from filling the FIFO before any data can leave. The receive-sync indication arrives asynchronously, so the block resynchronizes it before using it. The block also produces one-cycle restart pulses for the negotiation engine. A pulse is issued when software re-enables negotiation, and also when the link drops after negotiation has finished.

Top module: `link_bringup_ctrl`

## Requirements
- R1: After reset, the configuration register reads 0. Negotiation is therefore disabled and the port is in forced mode. At the same time tx_en_o is 0, tx_stat_o is 2'b10, an_restart_o is 0, stat_rx_sync_o is 0 and stat_an_done_o is 0.
- R2: stat_rx_sync_o equals the value rx_sync_i had two rising clock edges earlier, because rx_sync_i passes through a two-flop synchronizer.
- R3: In forced mode (register bit 5 = 0), tx_en_o takes the value of stat_rx_sync_o one edge later. In this mode an_complete_i has no effect on tx_en_o.
- R4: tx_stat_o is 2'b10 (satisfied) in every cycle that tx_en_o is 0, and 2'b00 (normal) in every cycle that tx_en_o is 1.
- R5: A cycle with cfg_wr_en_i high loads cfg_wr_data_i into the register at that edge. The register is visible on cfg_o. an_mode_o shows bit 5 of the register, and a value of 1 means negotiation mode.
- R6: A write that takes bit 5 from 0 to 1 raises an_restart_o for exactly the one cycle after that edge. A write that leaves bit 5 unchanged, or clears it, raises no pulse.
- R7: In negotiation mode, stat_an_done_o is set at the edge where an_complete_i and link_up_i are both high. One edge later, tx_en_o becomes stat_rx_sync_o AND stat_an_done_o.
- R8: In negotiation mode with stat_an_done_o set, link_up_i low at an edge pulses an_restart_o for one cycle and clears stat_an_done_o at that same edge. tx_en_o falls one edge later.
- R9: stat_an_done_o is 0 whenever an_mode_o is 0. Clearing bit 5 clears stat_an_done_o at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en_i | input | 1 | Configuration register write strobe |
| cfg_wr_data_i | input | 8 | Configuration write data; bit 5 enables negotiation |
| rx_sync_i | input | 1 | Receive synchronization from PCS, asynchronous |
| an_complete_i | input | 1 | Negotiation engine reports completion |
| link_up_i | input | 1 | Link-up indication |
| cfg_o | output | 8 | Configuration register contents |
| an_mode_o | output | 1 | 1 = negotiation mode, 0 = forced mode |
| an_restart_o | output | 1 | One-cycle negotiation restart pulse |
| tx_en_o | output | 1 | Transmit path enable |
| tx_stat_o | output | 2 | Status to host FIFO: 2'b10 satisfied, 2'b00 normal |
| stat_rx_sync_o | output | 1 | Synchronized receive-sync status bit |
| stat_an_done_o | output | 1 | Negotiation-complete status bit |

## Verification
Register writes and link-drop events show up on an_restart_o, cfg_o, an_mode_o and stat_an_done_o right after the edge that samples them. stat_rx_sync_o lags rx_sync_i by two edges. tx_en_o and tx_stat_o trail the status bits by one further edge, so a change on rx_sync_i reaches the transmit gate three edges after it is applied. The bench drives inputs on falling edges and advances exactly one rising edge before each sample. Every check therefore lands on the cycle worked out for it, including the cycle just before a change is due. The mode, completion and sync combinations are swept exhaustively, and each combination starts from a fresh reset so that no latched completion carries over between them.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        TXS_NORMAL    = 2'b00,
        TXS_SATISFIED = 2'b10
    } tx_stat_e;

endpackage

// File: rtl/lbc_sync.sv
module lbc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lbc_mode_ctrl.sv
module lbc_mode_ctrl #(
    parameter int CFG_W  = 8,
    parameter int AN_BIT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             link_up,
    input  logic             an_complete,
    output logic [CFG_W-1:0] cfg,
    output logic             an_en,
    output logic             restart,
    output logic             done
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             restart;
        logic             done;
    } mode_st_t;

    mode_st_t st_d, st_q;
    logic     en_now, en_next, rise, drop;

    always_comb begin
        st_d    = st_q;
        en_now  = st_q.cfg[AN_BIT];
        if (wr_en) st_d.cfg = wr_data;
        en_next = st_d.cfg[AN_BIT];
        rise    = wr_en && en_next && !en_now;
        drop    = en_now && st_q.done && !link_up;
        st_d.restart = rise || drop;
        if (st_d.restart || !en_next)       st_d.done = 1'b0;
        else if (an_complete && link_up)    st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg     = st_q.cfg;
    assign an_en   = st_q.cfg[AN_BIT];
    assign restart = st_q.restart;
    assign done    = st_q.done;
endmodule

// File: rtl/lbc_tx_gate.sv
module lbc_tx_gate
    import lbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sync_ok,
    input  logic     an_en,
    input  logic     an_done,
    output logic     tx_en,
    output tx_stat_e tx_stat
);
    typedef struct packed {
        logic     en;
        tx_stat_e stat;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d.en   = sync_ok && (!an_en || an_done);
        st_d.stat = st_d.en ? TXS_NORMAL : TXS_SATISFIED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.stat <= TXS_SATISFIED;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_en   = st_q.en;
    assign tx_stat = st_q.stat;
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
    import lbc_pkg::*;
#(
    parameter int CFG_W       = 8,
    parameter int AN_BIT      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en_i,
    input  logic [CFG_W-1:0] cfg_wr_data_i,
    input  logic             rx_sync_i,
    input  logic             an_complete_i,
    input  logic             link_up_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic             an_mode_o,
    output logic             an_restart_o,
    output logic             tx_en_o,
    output logic [1:0]       tx_stat_o,
    output logic             stat_rx_sync_o,
    output logic             stat_an_done_o
);
    logic     sync_ok, an_en, an_done;
    tx_stat_e stat_e;

    lbc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_sync_i),
        .dout (sync_ok)
    );

    lbc_mode_ctrl #(.CFG_W(CFG_W), .AN_BIT(AN_BIT)) i_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en_i),
        .wr_data    (cfg_wr_data_i),
        .link_up    (link_up_i),
        .an_complete(an_complete_i),
        .cfg        (cfg_o),
        .an_en      (an_en),
        .restart    (an_restart_o),
        .done       (an_done)
    );

    lbc_tx_gate i_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_ok(sync_ok),
        .an_en  (an_en),
        .an_done(an_done),
        .tx_en  (tx_en_o),
        .tx_stat(stat_e)
    );

    assign tx_stat_o      = stat_e;
    assign an_mode_o      = an_en;
    assign stat_rx_sync_o = sync_ok;
    assign stat_an_done_o = an_done;
endmodule

// File: rtl/lbc_chk.sv
module lbc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_up_i,
    input logic       an_mode_o,
    input logic       an_restart_o,
    input logic       tx_en_o,
    input logic [1:0] tx_stat_o,
    input logic       stat_rx_sync_o,
    input logic       stat_an_done_o
);
    // R6
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_restart_o |=> !an_restart_o);

    // R6
    restart_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_mode_o) |-> an_restart_o);

    // R3
    no_tx_without_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rx_sync_o |=> !tx_en_o);

    // R7
    no_tx_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_mode_o && !stat_an_done_o) |=> !tx_en_o);

    // R8
    link_drop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_mode_o && stat_an_done_o && !link_up_i) |=> (an_restart_o && !stat_an_done_o));

    // R9
    done_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !an_mode_o |-> !stat_an_done_o);

    // R4
    stat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_stat_o == 2'b00) || (tx_stat_o == 2'b10));
endmodule

bind link_bringup_ctrl lbc_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_up_i     (link_up_i),
    .an_mode_o     (an_mode_o),
    .an_restart_o  (an_restart_o),
    .tx_en_o       (tx_en_o),
    .tx_stat_o     (tx_stat_o),
    .stat_rx_sync_o(stat_rx_sync_o),
    .stat_an_done_o(stat_an_done_o)
);

// File: tb/test_link_bringup_ctrl.sv
module test_link_bringup_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rx_sync = 1'b0;
    logic       an_cpl = 1'b0;
    logic       link_up = 1'b0;
    logic [7:0] cfg;
    logic       an_mode, restart, tx_en, s_sync, s_done;
    logic [1:0] tx_stat;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    link_bringup_ctrl i_link_bringup_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en_i(wr_en), .cfg_wr_data_i(wr_data),
        .rx_sync_i(rx_sync), .an_complete_i(an_cpl), .link_up_i(link_up),
        .cfg_o(cfg), .an_mode_o(an_mode), .an_restart_o(restart), .tx_en_o(tx_en),
        .tx_stat_o(tx_stat), .stat_rx_sync_o(s_sync), .stat_an_done_o(s_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        rx_sync = 1'b0; an_cpl = 1'b0; link_up = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 cfg", cfg, 0);
        chk("R1 mode", an_mode, 0);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 tx_stat", tx_stat, 2);
        chk("R1 restart", restart, 0);
        chk("R1 sync", s_sync, 0);
        chk("R1 done", s_done, 0);

        // R2 and R3: sync latency in forced mode
        rx_sync = 1'b1; an_cpl = 1'b0;
        tick();
        chk("R2 sync after 1 edge", s_sync, 0);
        tick();
        chk("R2 sync after 2 edges", s_sync, 1);
        chk("R3 tx_en not yet", tx_en, 0);
        chk("R4 stat satisfied", tx_stat, 2);
        tick();
        chk("R3 tx_en forced", tx_en, 1);
        chk("R4 stat normal", tx_stat, 0);
        rx_sync = 1'b0;
        tick(2);
        chk("R2 sync drop", s_sync, 0);
        chk("R3 tx held one edge", tx_en, 1);
        tick();
        chk("R3 tx off", tx_en, 0);
        chk("R4 stat back satisfied", tx_stat, 2);

        // R5 and R6: register writes and restart pulse
        write_cfg(8'hDF);
        chk("R5 cfg other bits", cfg, 8'hDF);
        chk("R5 mode stays forced", an_mode, 0);
        chk("R6 no pulse bit5 low", restart, 0);
        write_cfg(8'h20);
        chk("R6 pulse on enable", restart, 1);
        chk("R5 mode on", an_mode, 1);
        tick();
        chk("R6 pulse one cycle", restart, 0);
        write_cfg(8'h20);
        chk("R6 no pulse rewrite", restart, 0);
        write_cfg(8'h00);
        chk("R6 no pulse clear", restart, 0);
        chk("R5 mode off", an_mode, 0);

        // R7, R8, R9: negotiation mode
        do_reset();
        rx_sync = 1'b1; link_up = 1'b1;
        write_cfg(8'h20);
        tick(3);
        chk("R7 tx off before done", tx_en, 0);
        an_cpl = 1'b1;
        tick();
        chk("R7 done set", s_done, 1);
        chk("R7 tx not yet", tx_en, 0);
        tick();
        chk("R7 tx on", tx_en, 1);
        an_cpl = 1'b0; link_up = 1'b0;
        tick();
        chk("R8 auto restart", restart, 1);
        chk("R8 done cleared", s_done, 0);
        chk("R8 tx still on", tx_en, 1);
        tick();
        chk("R8 restart single", restart, 0);
        chk("R8 tx off", tx_en, 0);
        link_up = 1'b1; an_cpl = 1'b1;
        tick();
        chk("R8 done again", s_done, 1);
        tick();
        chk("R8 tx back on", tx_en, 1);
        an_cpl = 1'b0;
        write_cfg(8'h00);
        chk("R9 done cleared with mode", s_done, 0);

        // Exhaustive sweep over mode, completion and sync
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 2; c++) begin
                for (int s = 0; s < 2; s++) begin
                    do_reset();
                    link_up = 1'b1;
                    write_cfg(m ? 8'h20 : 8'h00);
                    an_cpl = c[0]; rx_sync = s[0];
                    tick(5);
                    chk("R7 R9 sweep done", s_done, m & c);
                    chk("R3 R7 sweep tx_en", tx_en, s & ((m == 0) | c));
                    chk("R4 sweep stat", tx_stat, (s & ((m == 0) | c)) ? 0 : 2);
                end
            end
        end

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule